// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block picks one winner among a set of interrupt requests and hands the CPU a single encoded vector number and a pending flag. There are three non-maskable causes (illegal opcode trap, software interrupt, external non-maskable pin) and twenty maskable causes. The non-maskable causes always come first. The maskable causes are held back as a group by the global mask bit from the condition code register. Each maskable cause, except the external interrupt pin, is also held back by its own enable bit.

Maskable causes compete in a fixed order, where a lower source index wins. A promotion register can name one maskable source, and that source then beats every other maskable source. Software loads this register through a one-cycle write strobe. A write is accepted only while the global mask bit is set. The outputs are registered, so a request that is present at a clock edge appears on the vector output just after that edge.

Top module: `irq_prio_resolver`

## Requirements
- R1: After a synchronous active-low reset, `irq_pending` is 0, `vector` is 0, and the promotion register holds source index 0. With index 0 promoted, the fixed order is unchanged.
- R2: While `i_mask` is 1, no maskable source can win. With no non-maskable request present, `irq_pending` is 0 in the following cycle.
- R3: A maskable source k competes only when `src_req[k]` and `src_en[k]` are both 1. Source 0 is the external interrupt pin and competes on `src_req[0]` alone, whatever `src_en[0]` holds.
- R4: Among the competing maskable sources, the one with the lowest index wins.
- R5: When the promotion register holds an index k below 20 and source k is competing, source k wins over every other maskable source.
- R6: A write to the promotion register (`sel_wr` high, with the index on `sel_wdata`) takes effect at a clock edge only if `i_mask` is 1 at that edge. Otherwise the register keeps its old value. The new value steers winners picked from the next edge onward.
- R7: A promotion value from 20 to 31 is stored but promotes nothing, so the default order applies.
- R8: The non-maskable requests ignore `i_mask` and `src_en`, and they beat every maskable source. Among themselves the order is illegal opcode, then software interrupt, then the non-maskable pin.
- R9: The vector encoding is 0 for illegal opcode, 1 for software interrupt, 2 for the non-maskable pin, and 3+k for maskable source k. The pending flag and the vector are registered: inputs sampled at edge n show up on the outputs after edge n, and both change together.
- R10: When nothing wins, `irq_pending` is 0 and `vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 20 | Maskable request lines, index 0 is the external pin |
| src_en | input | 20 | Local enable per maskable source (bit 0 ignored) |
| i_mask | input | 1 | Global interrupt mask, 1 blocks maskable sources |
| nmi_illop | input | 1 | Illegal opcode trap request |
| nmi_swi | input | 1 | Software interrupt request |
| nmi_pin | input | 1 | Non-maskable pin request |
| sel_wr | input | 1 | Write strobe for the promotion register |
| sel_wdata | input | 5 | Source index to promote |
| irq_pending | output | 1 | A winner exists |
| vector | output | 5 | Encoded winner |

## Verification
Promotion is the hardest case to reach from the ports. The register can only be loaded while the global mask is set, and its effect can only be seen once the mask is clear again. The stimulus therefore writes an index with the mask set, then clears the mask, and then raises both the promoted source and a lower-index competitor. A write tried with the mask clear is checked the same way: the later winner shows whether the old promotion is still in force. Random cycles that toggle the mask, the strobe and the requests are compared against a behavioural model on every clock.

// File: rtl/irq_prio_pkg.sv
// Package: shared constants for the interrupt priority resolver.
// Assumes non-maskable causes take the lowest vector codes, in a fixed order.
package irq_prio_pkg;
    localparam int NUM_SRC_DFLT = 20;
    localparam int NUM_NMI      = 3;
    localparam int EXT_IDX_DFLT = 0;

    typedef enum logic [1:0] {
        NMI_ILLOP = 2'd0,
        NMI_SWI   = 2'd1,
        NMI_PIN   = 2'd2
    } nmi_code_e;
endpackage

// File: rtl/irq_src_qualify.sv
// Module: qualifies each maskable request with its enable and the global mask.
// Assumes the source at EXT_IDX has no local enable and is gated only by the mask.
module irq_src_qualify #(
    parameter int NUM_SRC = 20,
    parameter int EXT_IDX = 0
) (
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               i_mask,
    output logic [NUM_SRC-1:0] qual
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_q
        localparam logic NO_EN = (k == EXT_IDX);
        // Per-source gate: request, local enable (or exempt), global mask clear.
        always_comb qual[k] = src_req[k] & (src_en[k] | NO_EN) & ~i_mask;
    end
endmodule

// File: rtl/irq_sel_reg.sv
// Module: promotion select register.
// Assumes a write is legal only while the global mask is set; other writes are dropped.
module irq_sel_reg #(
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    input  logic             i_mask,
    output logic [SEL_W-1:0] sel_q
);
    // Load on a qualified write, clear to source 0 on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              sel_q <= '0;
        else if (wr && i_mask)   sel_q <= wdata;
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module: picks one maskable winner, lowest index first, with one promoted index.
// Assumes a promotion index at or above NUM_SRC has no effect.
module irq_prio_pick #(
    parameter int NUM_SRC = 20,
    parameter int SEL_W   = 5
) (
    input  logic [NUM_SRC-1:0] qual,
    input  logic [SEL_W-1:0]   sel,
    output logic               found,
    output logic [SEL_W-1:0]   idx
);
    logic             dflt_found;
    logic [SEL_W-1:0] dflt_idx;
    logic             promo_hit;

    // Default order: scan from the top so the lowest set index remains.
    always_comb begin
        dflt_found = 1'b0;
        dflt_idx   = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (qual[k]) begin
                dflt_found = 1'b1;
                dflt_idx   = SEL_W'(k);
            end
        end
    end

    // Promotion applies only for a defined, competing source.
    always_comb begin
        promo_hit = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel == SEL_W'(k) && qual[k]) promo_hit = 1'b1;
        end
    end

    // Final selection between promoted and default winner.
    always_comb begin
        found = dflt_found;
        idx   = promo_hit ? sel : dflt_idx;
    end
endmodule

// File: rtl/irq_prio_resolver.sv
// Module: top of the interrupt priority resolver.
// Non-maskable causes beat maskable ones; the winner is registered.
// Assumes a synchronous active-low reset and single-cycle request sampling.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = NUM_SRC_DFLT,
    parameter int EXT_IDX = EXT_IDX_DFLT,
    localparam int SEL_W  = $clog2(NUM_SRC),
    localparam int VEC_W  = $clog2(NUM_SRC + NUM_NMI)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               i_mask,
    input  logic               nmi_illop,
    input  logic               nmi_swi,
    input  logic               nmi_pin,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel_wdata,
    output logic               irq_pending,
    output logic [VEC_W-1:0]   vector
);
    logic [NUM_SRC-1:0] qual;
    logic [SEL_W-1:0]   sel_q;
    logic               m_found;
    logic [SEL_W-1:0]   m_idx;
    logic               nxt_pend;
    logic [VEC_W-1:0]   nxt_vec;

    irq_src_qualify #(.NUM_SRC(NUM_SRC), .EXT_IDX(EXT_IDX)) u_qual (
        .src_req(src_req), .src_en(src_en), .i_mask(i_mask), .qual(qual)
    );

    irq_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_wdata),
        .i_mask(i_mask), .sel_q(sel_q)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick (
        .qual(qual), .sel(sel_q), .found(m_found), .idx(m_idx)
    );

    // Rank non-maskable causes first, then the maskable winner.
    always_comb begin
        nxt_pend = 1'b1;
        nxt_vec  = '0;
        if (nmi_illop)      nxt_vec = VEC_W'(NMI_ILLOP);
        else if (nmi_swi)   nxt_vec = VEC_W'(NMI_SWI);
        else if (nmi_pin)   nxt_vec = VEC_W'(NMI_PIN);
        else if (m_found)   nxt_vec = VEC_W'(NUM_NMI) + VEC_W'(m_idx);
        else                nxt_pend = 1'b0;
    end

    // Output register for pending flag and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pending <= 1'b0;
            vector      <= '0;
        end else begin
            irq_pending <= nxt_pend;
            vector      <= nxt_vec;
        end
    end
endmodule

// File: rtl/irq_prio_checker.sv
// Module: property checker bound to the resolver top.
// Assumes the promotion register contents are visible as sel_q inside the top.
module irq_prio_checker #(
    parameter int NUM_SRC = 20,
    parameter int SEL_W   = 5,
    parameter int VEC_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i_mask,
    input logic             nmi_illop,
    input logic             nmi_swi,
    input logic             nmi_pin,
    input logic [SEL_W-1:0] sel_q,
    input logic             irq_pending,
    input logic [VEC_W-1:0] vector
);
    // R10: idle output carries code 0
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |-> vector == '0);

    // R2: mask set and no non-maskable request means nothing pending
    p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(i_mask) && !$past(nmi_illop) && !$past(nmi_swi)
         && !$past(nmi_pin)) |-> !irq_pending);

    // R8: illegal opcode always wins with code 0
    p_illop_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(nmi_illop)) |-> (irq_pending && vector == '0));

    // R6: promotion register unchanged while mask is clear
    p_sel_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(i_mask)) |-> $stable(sel_q));

    // R9: a pending vector lies in the defined code range
    p_vec_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (int'(vector) < NUM_SRC + 3));
endmodule

bind irq_prio_resolver irq_prio_checker #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .i_mask(i_mask), .nmi_illop(nmi_illop),
    .nmi_swi(nmi_swi), .nmi_pin(nmi_pin), .sel_q(sel_q),
    .irq_pending(irq_pending), .vector(vector)
);

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;
    localparam int N = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic [N-1:0] src_en = '0;
    logic        i_mask = 1'b1;
    logic        nmi_illop = 1'b0, nmi_swi = 1'b0, nmi_pin = 1'b0;
    logic        sel_wr = 1'b0;
    logic [4:0]  sel_wdata = '0;
    logic        irq_pending;
    logic [4:0]  vector;

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model state
    int  m_sel = 0;
    bit  e_pend = 0;
    int  e_vec = 0;

    always #2.5 clk = ~clk;

    irq_prio_resolver uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .i_mask(i_mask), .nmi_illop(nmi_illop), .nmi_swi(nmi_swi),
        .nmi_pin(nmi_pin), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .irq_pending(irq_pending), .vector(vector)
    );

    function automatic bool_competes(int k);
        return src_req[k] && (src_en[k] || k == 0) && !i_mask;
    endfunction

    // Reference model: updated at each rising edge from the settled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_pend = 0; e_vec = 0; m_sel = 0;
        end else begin
            int w;
            w = -1;
            if (nmi_illop) w = 0;
            else if (nmi_swi) w = 1;
            else if (nmi_pin) w = 2;
            else begin
                if (m_sel < N && bool_competes(m_sel)) w = 3 + m_sel;
                else
                    for (int k = N - 1; k >= 0; k--)
                        if (bool_competes(k)) w = 3 + k;
            end
            e_pend = (w >= 0);
            e_vec  = (w >= 0) ? w : 0;
            if (sel_wr && i_mask) m_sel = sel_wdata;
        end
    end

    task automatic compare();
        checks++;
        if (irq_pending !== e_pend || int'(vector) !== e_vec) begin
            fails++;
            $display("FAIL %s: actual pend=%0b vec=%0d expected pend=%0b vec=%0d",
                     cur_req, irq_pending, vector, e_pend, e_vec);
        end
    endtask

    // One clock: wait for the edge, check after it settles.
    task automatic step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic clear_in();
        src_req = '0; src_en = '0; nmi_illop = 0; nmi_swi = 0; nmi_pin = 0;
        sel_wr = 0;
    endtask

    task automatic write_sel(input logic [4:0] v);
        sel_wr = 1; sel_wdata = v; step(); sel_wr = 0;
    endtask

    task automatic expect_vec(input string tag, input bit p, input int v);
        checks++;
        if (irq_pending !== p || int'(vector) !== v) begin
            fails++;
            $display("FAIL %s: actual pend=%0b vec=%0d expected pend=%0b vec=%0d",
                     tag, irq_pending, vector, p, v);
        end
    endtask

    initial begin
        // R1: reset state
        src_req = '1; src_en = '1; i_mask = 0;
        step(); step();
        expect_vec("R1", 0, 0);
        rst_n = 1; clear_in(); #0;
        step();
        cur_req = "R10"; step();
        expect_vec("R10", 0, 0);

        // R4: default order, with reset promotion of source 0
        cur_req = "R4"; i_mask = 0;
        src_en = '1; src_req = 20'b0000_0000_0100_1000_0000; step(); step();
        expect_vec("R4", 1, 3 + 7);
        src_req[0] = 1; step(); step();
        expect_vec("R4", 1, 3);

        // R3: enable required except source 0
        cur_req = "R3"; src_en = '0; src_req = 20'h0_0010; step(); step();
        expect_vec("R3", 0, 0);
        src_req = 20'h0_0011; step(); step();
        expect_vec("R3", 1, 3);
        src_req = 20'h8_0000; src_en = 20'h8_0000; step(); step();
        expect_vec("R3", 1, 3 + 19);

        // R2: global mask blocks all maskable
        cur_req = "R2"; i_mask = 1; src_req = '1; src_en = '1; step(); step();
        expect_vec("R2", 0, 0);

        // R5: promote source 12 while masked, then unmask
        cur_req = "R5"; clear_in(); write_sel(5'd12);
        i_mask = 0; src_en = '1; src_req = 20'h0_1022; step(); step();
        expect_vec("R5", 1, 3 + 12);
        src_req = 20'h0_0022; step(); step();
        expect_vec("R5", 1, 3 + 1);

        // R6: write with mask clear is ignored (12 stays promoted)
        cur_req = "R6"; src_req = '0; write_sel(5'd5);
        src_req = 20'h0_1020; step(); step();
        expect_vec("R6", 1, 3 + 12);

        // R7: out-of-range promotion falls back to default order
        cur_req = "R7"; i_mask = 1; src_req = '0; write_sel(5'd25);
        i_mask = 0; src_req = 20'h0_1020; step(); step();
        expect_vec("R7", 1, 3 + 5);

        // R8: non-maskable order and mask independence
        cur_req = "R8"; i_mask = 1; src_req = '1;
        nmi_pin = 1; step(); step(); expect_vec("R8", 1, 2);
        nmi_swi = 1; step(); step(); expect_vec("R8", 1, 1);
        nmi_illop = 1; step(); step(); expect_vec("R8", 1, 0);
        i_mask = 0; nmi_illop = 0; nmi_swi = 0; step(); step();
        expect_vec("R8", 1, 2);

        // R9: registered timing, change visible only after the edge
        cur_req = "R9"; clear_in(); step();
        src_req = 20'h0_0100; src_en = 20'h0_0100;
        #1; expect_vec("R9", 0, 0);
        step(); expect_vec("R9", 1, 3 + 8);

        // Random mix compared each cycle
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            src_req = 20'($urandom) & 20'($urandom);
            src_en = 20'($urandom);
            i_mask = ($urandom % 3) == 0;
            nmi_illop = ($urandom % 16) == 0;
            nmi_swi = ($urandom % 16) == 0;
            nmi_pin = ($urandom % 16) == 0;
            sel_wr = ($urandom % 8) == 0;
            sel_wdata = 5'($urandom);
            step();
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule